// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock Unit

This unit resolves data hazards for a five-stage in-order integer pipeline: fetch, decode/register-read, execute, memory and writeback, one clock each. It looks at the register specifiers and control bits in the pipeline registers. For each execute-stage ALU operand it produces a select that picks one of three values: the register-file value, the result held in the execute/memory register, or the value held in the memory/writeback register. When the instruction in execute is a load whose destination is read by the instruction in decode, the unit freezes the program counter and the fetch/decode register for one cycle. In that cycle it zeroes the control bits entering execute, which gives the same effect as a nop placed after the load.

It also provides the decode-stage read bypass. A register that writeback is writing in the same cycle that decode reads it returns the new value. This matches a register file that writes in the first half of the cycle and reads in the second half.

The logic is purely combinational from its pipeline inputs to its outputs. The clock and reset are used only by the embedded property checks.

Top module: `hazardUnit`

## Requirements
- R1: When the memory-stage instruction writes a non-zero register equal to an execute-stage source, that operand's select is 2'b10 (forward from the execute/memory register).
- R2: When only the writeback-stage instruction writes a non-zero register equal to an execute-stage source, that operand's select is 2'b01 (forward from the memory/writeback register).
- R3: When both the memory and writeback stages match the same source, the select is 2'b10, because the younger result wins. The value 2'b11 never appears.
- R4: A producer with its write enable low, or with destination register 0, never causes forwarding (select 2'b00) and never causes a stall.
- R5: A load in execute with a non-zero destination that equals decode's first source, or equals decode's second source while decode reads that source, drives pcWrite=0, ifIdWrite=0 and exBubble=1.
- R6: No stall is raised if the execute instruction is not a load. No stall is raised if the only match is on the second source and decode does not read it. No stall is raised without a match.
- R7: When writeback writes a non-zero register that decode reads in the same cycle, the decode read data equals the writeback data.
- R8: When writeback is not writing, or is writing register 0, the decode read data equals the raw register-file data.
- R9: In a pipeline driven by the unit's outputs, a load-use stall lasts exactly one cycle. A seven-instruction sequence with two load-use pairs finishes in 13 cycles. Its reordered form with no such pairs finishes in 11 cycles.
- R10: The two operand selects are computed independently, each from its own source specifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rstN | input | 1 | Active-low reset for the property checks |
| idRs | input | AW | Decode first source register |
| idRt | input | AW | Decode second source register |
| idUsesRt | input | 1 | Decode instruction reads its second source |
| exRs | input | AW | Execute first source register |
| exRt | input | AW | Execute second source register |
| exRd | input | AW | Execute destination register |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| memRd | input | AW | Memory-stage destination register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | AW | Writeback destination register |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| wbData | input | DW | Writeback data |
| rfRsData | input | DW | Raw register-file read of idRs |
| rfRtData | input | DW | Raw register-file read of idRt |
| fwdA | output | 2 | First ALU operand select |
| fwdB | output | 2 | Second ALU operand select |
| pcWrite | output | 1 | Program counter update enable |
| ifIdWrite | output | 1 | Fetch/decode register load enable |
| exBubble | output | 1 | Zero the control bits entering execute |
| idRsData | output | DW | Bypassed decode first-source data |
| idRtData | output | DW | Bypassed decode second-source data |

## Verification
The one-cycle stall property assumes a correctly wired pipeline. In the cycle after a stall, execute holds the injected bubble, so exMemRead is low. The bench keeps to this in two ways. Every directed or swept vector is followed by an idle cycle with all enables low. The sequence runs use a bench pipeline model that applies the unit's stall outputs and moves a bubble into execute. The select and bypass properties hold for any input values.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic holdFront;
    logic injectBubble;
  } hzdStrobe_t;
endpackage

// File: rtl/fwdPick.sv
module fwdPick
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] memRd,
  input  logic          memWe,
  input  logic [AW-1:0] wbRd,
  input  logic          wbWe,
  output fwdSel_e       sel
);
  logic memHit;
  logic wbHit;

  always_comb begin
    memHit = memWe && (memRd != '0) && (memRd == src);
    wbHit  = wbWe && (wbRd != '0) && (wbRd == src);
    if (memHit)     sel = SEL_MEM;
    else if (wbHit) sel = SEL_WB;
    else            sel = SEL_RF;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel)); // R3
  AST_ZERO_SRC_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (src == '0) |-> (sel == SEL_RF)); // R4
endmodule

// File: rtl/rfBypass.sv
module rfBypass #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] src,
  input  logic [DW-1:0] rfData,
  input  logic [AW-1:0] wbRd,
  input  logic          wbWe,
  input  logic [DW-1:0] wbData,
  output logic [DW-1:0] data
);
  logic hit;

  always_comb begin
    hit  = wbWe && (wbRd != '0) && (wbRd == src);
    data = hit ? wbData : rfData;
  end

  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!wbWe || (wbRd == '0)) |-> (data == rfData)); // R8
  AST_BYPASS_ON: assert property (@(posedge clk) disable iff (!rstN)
    (wbWe && (wbRd != '0) && (wbRd == src)) |-> (data == wbData)); // R7
endmodule

// File: rtl/hzdPath.sv
module hzdPath
  import hzd_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int NOPS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NOPS-1:0][AW-1:0]  exSrc,
  input  logic [NOPS-1:0][AW-1:0]  idSrc,
  input  logic [NOPS-1:0][DW-1:0]  rfData,
  input  logic [AW-1:0]            memRd,
  input  logic                     memRegWrite,
  input  logic [AW-1:0]            wbRd,
  input  logic                     wbRegWrite,
  input  logic [DW-1:0]            wbData,
  output logic [NOPS-1:0][1:0]     sel,
  output logic [NOPS-1:0][DW-1:0]  idData
);
  for (genvar g = 0; g < NOPS; g++) begin : gOperand
    fwdSel_e pick;

    fwdPick #(.AW(AW)) uPick (
      .clk   (clk),
      .rstN  (rstN),
      .src   (exSrc[g]),
      .memRd (memRd),
      .memWe (memRegWrite),
      .wbRd  (wbRd),
      .wbWe  (wbRegWrite),
      .sel   (pick)
    );

    assign sel[g] = pick;

    rfBypass #(.AW(AW), .DW(DW)) uByp (
      .clk    (clk),
      .rstN   (rstN),
      .src    (idSrc[g]),
      .rfData (rfData[g]),
      .wbRd   (wbRd),
      .wbWe   (wbRegWrite),
      .wbData (wbData),
      .data   (idData[g])
    );
  end
endmodule

// File: rtl/hzdCtrl.sv
module hzdCtrl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] idRs,
  input  logic [AW-1:0] idRt,
  input  logic          idUsesRt,
  input  logic [AW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exMemRead,
  output hzdStrobe_t    strobe
);
  logic loadLive;
  logic rsHit;
  logic rtHit;
  logic stall;

  always_comb begin
    loadLive = exMemRead && exRegWrite && (exRd != '0);
    rsHit    = (exRd == idRs);
    rtHit    = idUsesRt && (exRd == idRt);
    stall    = loadLive && (rsHit || rtHit);
    strobe.holdFront    = stall;
    strobe.injectBubble = stall;
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall); // R9
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRead |-> !stall); // R6
  AST_DEST0_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0) |-> !stall); // R4
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hzd_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] idRs,
  input  logic [AW-1:0] idRt,
  input  logic          idUsesRt,
  input  logic [AW-1:0] exRs,
  input  logic [AW-1:0] exRt,
  input  logic [AW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exMemRead,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic [DW-1:0] wbData,
  input  logic [DW-1:0] rfRsData,
  input  logic [DW-1:0] rfRtData,
  output logic [1:0]    fwdA,
  output logic [1:0]    fwdB,
  output logic          pcWrite,
  output logic          ifIdWrite,
  output logic          exBubble,
  output logic [DW-1:0] idRsData,
  output logic [DW-1:0] idRtData
);
  localparam int NOPS = 2;

  hzdStrobe_t strobe;
  logic [NOPS-1:0][1:0]    sel;
  logic [NOPS-1:0][DW-1:0] idData;

  hzdCtrl #(.AW(AW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .idRs       (idRs),
    .idRt       (idRt),
    .idUsesRt   (idUsesRt),
    .exRd       (exRd),
    .exRegWrite (exRegWrite),
    .exMemRead  (exMemRead),
    .strobe     (strobe)
  );

  hzdPath #(.AW(AW), .DW(DW), .NOPS(NOPS)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .exSrc       ({exRt, exRs}),
    .idSrc       ({idRt, idRs}),
    .rfData      ({rfRtData, rfRsData}),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .wbData      (wbData),
    .sel         (sel),
    .idData      (idData)
  );

  assign fwdA      = sel[0];
  assign fwdB      = sel[1];
  assign idRsData  = idData[0];
  assign idRtData  = idData[1];
  assign pcWrite   = !strobe.holdFront;
  assign ifIdWrite = !strobe.holdFront;
  assign exBubble  = strobe.injectBubble;

  AST_NONLOAD_NO_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!exRegWrite) |-> (pcWrite && ifIdWrite && !exBubble)); // R4
endmodule

// File: tb/sim_hazardUnit.sv
module sim_hazardUnit;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] idRs, idRt, exRs, exRt, exRd, memRd, wbRd;
  logic idUsesRt, exRegWrite, exMemRead, memRegWrite, wbRegWrite;
  logic [DW-1:0] wbData, rfRsData, rfRtData;
  logic [1:0] fwdA, fwdB;
  logic pcWrite, ifIdWrite, exBubble;
  logic [DW-1:0] idRsData, idRtData;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  hazardUnit #(.AW(AW), .DW(DW)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    idRs = '0; idRt = '0; idUsesRt = 0; exRs = '0; exRt = '0; exRd = '0;
    exRegWrite = 0; exMemRead = 0; memRd = '0; memRegWrite = 0;
    wbRd = '0; wbRegWrite = 0; wbData = 32'hDEAD_0001;
    rfRsData = 32'h1111_0000; rfRtData = 32'h2222_0000;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic nextVec();
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  // bench pipeline model: op 0 reg-reg ALU, 1 load, 2 store, 3 immediate ALU
  int opk[16], fd[16], fs[16], ft[16];

  function automatic logic [AW-1:0] destOf(input int i);
    if (i < 0) return '0;
    if (opk[i] == 0) return AW'(fd[i]);
    if (opk[i] == 2) return '0;
    return AW'(ft[i]);
  endfunction

  function automatic logic weOf(input int i);
    return (i >= 0) && (opk[i] != 2);
  endfunction

  task automatic setI(input int i, input int op, input int d, input int s, input int t);
    opk[i] = op; fd[i] = d; fs[i] = s; ft[i] = t;
  endtask

  task automatic runProg(input int n, input int expCycles, input int expStalls, input string tag);
    int ifS, idS, exS, memS, wbS, pc, cyc, stalls;
    logic st;
    ifS = 0; idS = -1; exS = -1; memS = -1; wbS = -1; pc = 1; cyc = 1; stalls = 0;
    while (wbS != n - 1 && cyc < 100) begin
      @(negedge clk);
      idle();
      idRs = (idS >= 0) ? AW'(fs[idS]) : '0;
      idRt = (idS >= 0) ? AW'(ft[idS]) : '0;
      idUsesRt = (idS >= 0) && (opk[idS] == 0 || opk[idS] == 2);
      exRd = destOf(exS); exRegWrite = weOf(exS);
      exMemRead = (exS >= 0) && (opk[exS] == 1);
      memRd = destOf(memS); memRegWrite = weOf(memS);
      wbRd = destOf(wbS); wbRegWrite = weOf(wbS);
      settle();
      st = !pcWrite;
      if (st) stalls++;
      wbS = memS; memS = exS;
      if (st) exS = -1;
      else begin
        exS = idS; idS = ifS;
        ifS = (pc < n) ? pc : -1;
        pc++;
      end
      cyc++;
    end
    chk({tag, " R9 cycles"}, 64'(cyc), 64'(expCycles));
    chk({tag, " R9 stalls"}, 64'(stalls), 64'(expStalls));
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // idle state after reset
    settle();
    chk("R4 idle fwdA", 64'(fwdA), 0); chk("R4 idle fwdB", 64'(fwdB), 0);
    chk("R5 idle pcWrite", 64'(pcWrite), 1); chk("R5 idle ifIdWrite", 64'(ifIdWrite), 1);
    chk("R5 idle bubble", 64'(exBubble), 0);
    chk("R8 idle rs", 64'(idRsData), 64'h1111_0000);

    // R1 / R10
    @(negedge clk); memRegWrite = 1; memRd = 5; exRs = 5; exRt = 6; settle();
    chk("R1 fwdA mem", 64'(fwdA), 2); chk("R10 fwdB untouched", 64'(fwdB), 0);
    nextVec(); memRegWrite = 1; memRd = 5; exRt = 5; exRs = 4; settle();
    chk("R10 fwdB mem", 64'(fwdB), 2); chk("R10 fwdA untouched", 64'(fwdA), 0);
    // R2
    nextVec(); wbRegWrite = 1; wbRd = 6; exRs = 6; settle();
    chk("R2 fwdA wb", 64'(fwdA), 1);
    // R3
    nextVec(); wbRegWrite = 1; wbRd = 7; memRegWrite = 1; memRd = 7; exRs = 7; exRt = 7; settle();
    chk("R3 fwdA both", 64'(fwdA), 2); chk("R3 fwdB both", 64'(fwdB), 2);
    // R4
    nextVec(); memRegWrite = 1; memRd = 0; exRs = 0; wbRegWrite = 1; wbRd = 0; settle();
    chk("R4 reg0 fwdA", 64'(fwdA), 0);
    nextVec(); memRegWrite = 0; memRd = 9; exRs = 9; settle();
    chk("R4 we low fwdA", 64'(fwdA), 0);
    nextVec(); exMemRead = 1; exRegWrite = 1; exRd = 0; idRs = 0; settle();
    chk("R4 load reg0 no stall", 64'(pcWrite), 1);
    nextVec(); exMemRead = 1; exRegWrite = 0; exRd = 3; idRs = 3; settle();
    chk("R4 load we low no stall", 64'(pcWrite), 1);
    // R5
    nextVec(); exMemRead = 1; exRegWrite = 1; exRd = 3; idRs = 3; settle();
    chk("R5 rs pcWrite", 64'(pcWrite), 0); chk("R5 rs ifIdWrite", 64'(ifIdWrite), 0);
    chk("R5 rs bubble", 64'(exBubble), 1);
    nextVec(); exMemRead = 1; exRegWrite = 1; exRd = 3; idRt = 3; idRs = 1; idUsesRt = 1; settle();
    chk("R5 rt bubble", 64'(exBubble), 1);
    // R6
    nextVec(); exMemRead = 1; exRegWrite = 1; exRd = 3; idRt = 3; idRs = 1; idUsesRt = 0; settle();
    chk("R6 rt unused", 64'(exBubble), 0);
    nextVec(); exMemRead = 0; exRegWrite = 1; exRd = 3; idRs = 3; settle();
    chk("R6 non-load", 64'(pcWrite), 1);
    // R7 / R8
    nextVec(); wbRegWrite = 1; wbRd = 4; idRs = 4; idRt = 4; wbData = 32'hCAFE_0004; settle();
    chk("R7 rs bypass", 64'(idRsData), 64'hCAFE_0004); chk("R7 rt bypass", 64'(idRtData), 64'hCAFE_0004);
    nextVec(); wbRegWrite = 1; wbRd = 0; idRs = 0; settle();
    chk("R8 reg0", 64'(idRsData), 64'h1111_0000);
    nextVec(); wbRegWrite = 0; wbRd = 4; idRt = 4; settle();
    chk("R8 we low", 64'(idRtData), 64'h2222_0000);

    // sweep: forwarding select over 8 registers (R1 R2 R3 R4)
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 8; w++) begin
          int e;
          nextVec();
          exRs = AW'(s); memRd = AW'(m); wbRd = AW'(w);
          memRegWrite = 1; wbRegWrite = ((s + m + w) % 3) != 0;
          settle();
          e = (m != 0 && m == s) ? 2 : ((wbRegWrite && w != 0 && w == s) ? 1 : 0);
          chk("R3 sweep fwdA", 64'(fwdA), 64'(e));
        end
    // sweep: load-use over 8 registers (R5 R6)
    for (int d = 0; d < 8; d++)
      for (int r = 0; r < 8; r++) begin
        nextVec();
        exMemRead = 1; exRegWrite = 1; exRd = AW'(d); idRs = AW'(r); idRt = AW'(d);
        idUsesRt = r[0];
        settle();
        chk("R5 sweep bubble", 64'(exBubble), 64'((d != 0) && (d == r || r[0])));
      end

    // sequence runs (R9)
    nextVec();
    setI(0, 1, 0, 8, 9); setI(1, 1, 0, 8, 10); setI(2, 0, 11, 9, 10); setI(3, 2, 0, 8, 11);
    setI(4, 1, 0, 8, 12); setI(5, 0, 13, 9, 12); setI(6, 2, 0, 8, 13);
    runProg(7, 13, 2, "R9 in-order");
    setI(0, 1, 0, 8, 9); setI(1, 1, 0, 8, 10); setI(2, 1, 0, 8, 12); setI(3, 0, 11, 9, 10);
    setI(4, 2, 0, 8, 11); setI(5, 0, 13, 9, 12); setI(6, 2, 0, 8, 13);
    runProg(7, 11, 0, "R9 reordered");
    setI(0, 1, 0, 8, 8); setI(1, 0, 9, 8, 8);
    runProg(2, 7, 1, "R9 load-add");
    setI(0, 1, 0, 1, 8); setI(1, 3, 0, 9, 8);
    runProg(2, 6, 0, "R6 load-imm");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule